// File: doc/BRIEF.md
# False Carrier Transmit Arbiter

This block sits between a host that offers frames one nibble at a time and a nibble-wide transmit bus. It normally passes host frames through. When the host raises a force-carrier control, the block fills the bus with a constant pattern and keeps transmit enable high for as long as the control stays high. This holds the line busy without sending a frame.

The forced mode and normal frames are arbitrated. A frame already on the bus always finishes first. A frame requested while the forced mode runs waits until the control drops. It then starts after a short quiet gap on the bus. While the forced pattern is on the bus, collision reports from the line are hidden from the host. Link status flows through untouched in every mode. The block never ends a forced period on its own, so a long forced period at 10 Mb/s is left for the host to manage.

Top module: `fc_tx_arbiter`

## Requirements
- R1: While forced mode is on the bus, `mii_txen_o` is 1 and `mii_txd_o` equals the parameter `FC_PATTERN` (default 4'h0) on every cycle. Forced output appears two cycles after the force input is first sampled high in idle.
- R2: If the force input rises while a frame is being sent, every remaining nibble of that frame is still taken and sent. Forced output then follows on the very next bus cycle after the last nibble, with no idle cycle between them.
- R3: A host request made while forced mode is active is not taken: `host_take_o` stays 0 for as long as the force input stays high.
- R4: After the force input falls, `mii_txen_o` is 0 for exactly `GAP_CYCLES` cycles. A pending frame then has its first nibble taken on the cycle where that gap begins its last cycle plus one, and the nibble appears on the bus on the cycle right after the gap.
- R5: `col_o` equals `col_i` except while the forced pattern is on the bus, when `col_o` is 0.
- R6: If the force input and a host request rise in the same cycle from idle, forced mode wins and the frame waits as in R3 and R4.
- R7: Forced mode has no time limit. It lasts, unbroken, for any number of cycles the force input is held (at least 3000 cycles).
- R8: `link_stat_o` equals `link_stat_i` on every cycle in every mode.
- R9: During reset, and while idle, `mii_txen_o` is 0, `mii_txd_o` is 4'h0 and `host_take_o` is 0.
- R10: From idle, a host request with force low is accepted at the next clock edge. `host_take_o` is then 1 for one cycle per nibble, and the last nibble is flagged by `host_last_i`. Each taken nibble appears on `mii_txd_o` one cycle after it is taken, with `mii_txen_o` high.
- R11: When the force input falls with no frame pending, the bus stays quiet after the forced pattern ends and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_force_i | input | 1 | Host request for continuous false carrier |
| host_req_i | input | 1 | Host has a frame ready (held until the last nibble is taken) |
| host_nib_i | input | 4 | Current frame nibble from host |
| host_last_i | input | 1 | Current nibble is the last of the frame |
| host_take_o | output | 1 | Current nibble is consumed at the next edge |
| col_i | input | 1 | Collision report from the line |
| col_o | output | 1 | Collision report toward the host, masked in forced mode |
| link_stat_i | input | STAT_W | Link status bits from the line side |
| link_stat_o | output | STAT_W | Link status bits toward management |
| mii_txen_o | output | 1 | Transmit enable on the nibble bus |
| mii_txd_o | output | 4 | Transmit nibble |

## Verification
The bench builds the block with `GAP_CYCLES` = 2 and `FC_PATTERN` = 4'hA. A nonzero pattern makes forced nibbles distinguishable from idle zeros and from frame data, and the two-cycle gap makes an off-by-one in the release timer visible. With frames of one to five nibbles, the force input is raised at every offset from the first nibble to two cycles after the frame ends. This covers mid-frame deferral, the exact end-of-frame edge and rise from idle, each with a second frame queued during the forced period. Separate runs cover force and request rising together, and a 3000-cycle forced period.

// File: rtl/fcta_pkg.sv
package fcta_pkg;

  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PACKET  = 3'd1,
    ST_FORCED  = 3'd2,
    ST_PENDING = 3'd3,
    ST_RELEASE = 3'd4
  } arb_state_e;

  // forced pattern owns the bus in these states
  function automatic logic in_forced(arb_state_e s);
    return (s == ST_FORCED) || (s == ST_PENDING);
  endfunction

  // nibble placed on the bus for the next cycle
  function automatic logic [NIB_W-1:0] tx_nibble(logic sending, logic forced,
                                                 logic [NIB_W-1:0] host_nib,
                                                 logic [NIB_W-1:0] pattern);
    if (forced)       return pattern;
    else if (sending) return host_nib;
    else              return '0;
  endfunction

  // collision seen by the host
  function automatic logic col_pass(logic col, logic forced_on_wire);
    return col & ~forced_on_wire;
  endfunction

endpackage

// File: rtl/fcta_gap_timer.sv
module fcta_gap_timer #(
  parameter int GAP_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(GAP_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign done_o  = run_i & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!at_last)   cnt_q <= cnt_q + CW'(1);
  end

  // R4: the gap counter never runs past its programmed length
  p_gap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !at_last) |=> (cnt_q != '0 || !run_i));

endmodule

// File: rtl/fcta_ctrl.sv
module fcta_ctrl
  import fcta_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       force_i,
  input  logic       req_i,
  input  logic       last_i,
  input  logic       gap_done_i,
  output arb_state_e state_o,
  output logic       take_o,
  output logic       fc_mode_o,
  output logic       rel_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (force_i)    state_d = req_i ? ST_PENDING : ST_FORCED;
        else if (req_i) state_d = ST_PACKET;
      end
      ST_PACKET: begin
        if (last_i)     state_d = force_i ? ST_FORCED : ST_IDLE;
      end
      ST_FORCED: begin
        if (!force_i)   state_d = ST_RELEASE;
        else if (req_i) state_d = ST_PENDING;
      end
      ST_PENDING: begin
        if (!force_i)   state_d = ST_RELEASE;
      end
      ST_RELEASE: begin
        if (force_i)         state_d = req_i ? ST_PENDING : ST_FORCED;
        else if (gap_done_i) state_d = req_i ? ST_PACKET : ST_IDLE;
      end
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o   = state_q;
  assign take_o    = (state_q == ST_PACKET);
  assign fc_mode_o = in_forced(state_q);
  assign rel_o     = (state_q == ST_RELEASE);

  // R2: a frame is never cut short before its last nibble
  p_frame_finish_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !last_i) |=> take_o);

  // R3: forced mode persists while the host holds the control
  p_hold_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_mode_o && force_i) |=> (fc_mode_o && !take_o));

  // R6: simultaneous rise of force and request from idle goes forced
  p_force_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && force_i && req_i) |=> (state_q == ST_PENDING));

endmodule

// File: rtl/fcta_tx_reg.sv
module fcta_tx_reg
  import fcta_pkg::*;
#(
  parameter logic [NIB_W-1:0] FC_PATTERN = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             fc_mode_i,
  input  logic [NIB_W-1:0] host_nib_i,
  output logic             txen_o,
  output logic [NIB_W-1:0] txd_o,
  output logic             fc_wire_o
);
  logic             txen_q;
  logic [NIB_W-1:0] txd_q;
  logic             fc_wire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txen_q    <= 1'b0;
      txd_q     <= '0;
      fc_wire_q <= 1'b0;
    end else begin
      txen_q    <= take_i | fc_mode_i;
      txd_q     <= tx_nibble(take_i, fc_mode_i, host_nib_i, FC_PATTERN);
      fc_wire_q <= fc_mode_i;
    end
  end

  assign txen_o    = txen_q;
  assign txd_o     = txd_q;
  assign fc_wire_o = fc_wire_q;

  // R10: a taken nibble shows on the bus one cycle later
  p_nibble_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !fc_mode_i) |=> (txen_o && txd_o == $past(host_nib_i)));

endmodule

// File: rtl/fcta_col_gate.sv
module fcta_col_gate
  import fcta_pkg::*;
#(
  parameter int STAT_W = 4
) (
  input  logic              fc_wire_i,
  input  logic              col_i,
  output logic              col_o,
  input  logic [STAT_W-1:0] stat_i,
  output logic [STAT_W-1:0] stat_o
);
  assign col_o  = col_pass(col_i, fc_wire_i);
  assign stat_o = stat_i;
endmodule

// File: rtl/fc_tx_arbiter.sv
module fc_tx_arbiter
  import fcta_pkg::*;
#(
  parameter logic [3:0] FC_PATTERN = 4'h0,
  parameter int         GAP_CYCLES = 1,
  parameter int         STAT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_force_i,
  input  logic              host_req_i,
  input  logic [3:0]        host_nib_i,
  input  logic              host_last_i,
  output logic              host_take_o,
  input  logic              col_i,
  output logic              col_o,
  input  logic [STAT_W-1:0] link_stat_i,
  output logic [STAT_W-1:0] link_stat_o,
  output logic              mii_txen_o,
  output logic [3:0]        mii_txd_o
);
  arb_state_e state;
  logic       take, fc_mode, rel, gap_done, fc_wire;

  fcta_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_i    (fc_force_i),
    .req_i      (host_req_i),
    .last_i     (host_last_i),
    .gap_done_i (gap_done),
    .state_o    (state),
    .take_o     (take),
    .fc_mode_o  (fc_mode),
    .rel_o      (rel)
  );

  fcta_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (rel),
    .done_o (gap_done)
  );

  fcta_tx_reg #(.FC_PATTERN(FC_PATTERN)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .fc_mode_i  (fc_mode),
    .host_nib_i (host_nib_i),
    .txen_o     (mii_txen_o),
    .txd_o      (mii_txd_o),
    .fc_wire_o  (fc_wire)
  );

  fcta_col_gate #(.STAT_W(STAT_W)) u_col (
    .fc_wire_i (fc_wire),
    .col_i     (col_i),
    .col_o     (col_o),
    .stat_i    (link_stat_i),
    .stat_o    (link_stat_o)
  );

  assign host_take_o = take;

  // R1: forced state puts the constant pattern on the bus next cycle
  p_fc_pattern_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fc_mode |=> (mii_txen_o && mii_txd_o == FC_PATTERN));

  // R4: release cycles leave the bus quiet
  p_gap_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> !mii_txen_o);

  // R5: no collision reaches the host while the pattern is sent
  p_col_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fc_mode |=> !col_o);

  // R9: idle leaves the bus quiet
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> (!mii_txen_o && mii_txd_o == 4'h0));

endmodule

// File: tb/fc_tx_arbiter_tb.sv
`timescale 1ns/1ps
module fc_tx_arbiter_tb;
  localparam int         GAP  = 2;
  localparam logic [3:0] PAT  = 4'hA;
  localparam int         SW   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fc_force_i = 1'b0, host_req_i = 1'b0, host_last_i = 1'b0, col_i = 1'b0;
  logic [3:0]    host_nib_i = '0;
  logic [SW-1:0] link_stat_i = '0;
  logic          host_take_o, col_o, mii_txen_o;
  logic [SW-1:0] link_stat_o;
  logic [3:0]    mii_txd_o;

  int checks = 0;
  int errors = 0;

  // host frame model
  bit h_active;
  int h_len, h_idx, h_base;
  bit took;

  always #2.5 clk = ~clk;

  fc_tx_arbiter #(.FC_PATTERN(PAT), .GAP_CYCLES(GAP), .STAT_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fc_force_i(fc_force_i), .host_req_i(host_req_i),
    .host_nib_i(host_nib_i), .host_last_i(host_last_i), .host_take_o(host_take_o),
    .col_i(col_i), .col_o(col_o), .link_stat_i(link_stat_i), .link_stat_o(link_stat_o),
    .mii_txen_o(mii_txen_o), .mii_txd_o(mii_txd_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit inwin(int t, int s, int n);
    return (t >= s) && (t < s + n);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fc_force_i = 0; host_req_i = 0; host_last_i = 0; col_i = 0; host_nib_i = '0;
    repeat (2) @(negedge clk);
    // R9: quiet outputs during reset
    chk(mii_txen_o == 1'b0, "R9", "txen in reset", mii_txen_o, 0);
    chk(mii_txd_o == 4'h0, "R9", "txd in reset", mii_txd_o, 0);
    chk(host_take_o == 1'b0, "R9", "take in reset", host_take_o, 0);
    rst_n = 1'b1;
    h_active = 0; h_idx = 0; h_len = 0; took = 0;
  endtask

  // la/lb: frame lengths; f: force rise tick (<0 none); d: force low tick
  // a0/b0: tick of first take; s: first forced tick on the bus
  task automatic run(input int la, input int a_req, input int f, input int d,
                     input int lb, input int b_req, input int a0, input int b0,
                     input int s, input string ftag, input string gtag);
    int tend;
    int fn;
    do_reset();
    fn = (f >= 0) ? (d + 2 - s) : 0;
    tend = d + GAP + lb + 6;
    if (tend < a0 + la + 4) tend = a0 + la + 4;
    for (int t = 0; t < tend; t++) begin
      bit   e_take, e_en, e_col, in_f;
      logic [3:0] e_d;
      string tg;
      @(negedge clk);
      if (took) begin
        h_idx++;
        if (h_idx == h_len) h_active = 0;
      end
      if (t == a_req && la > 0) begin h_active = 1; h_len = la; h_idx = 0; h_base = 1;  end
      if (t == b_req && lb > 0) begin h_active = 1; h_len = lb; h_idx = 0; h_base = 11; end
      fc_force_i  = (f >= 0) && (t >= f) && (t < d);
      host_req_i  = h_active;
      host_nib_i  = 4'(h_base + h_idx);
      host_last_i = h_active && (h_idx == h_len - 1);
      col_i       = (t % 3 == 1);
      link_stat_i = SW'(t);
      #1;
      took = host_take_o;

      in_f   = inwin(t, s, fn);
      e_take = inwin(t, a0, la) || inwin(t, b0, lb);
      e_en   = inwin(t, a0 + 1, la) || in_f || inwin(t, b0 + 1, lb);
      if (in_f)                        e_d = PAT;
      else if (inwin(t, a0 + 1, la))   e_d = 4'(1 + t - a0 - 1);
      else if (inwin(t, b0 + 1, lb))   e_d = 4'(11 + t - b0 - 1);
      else                             e_d = 4'h0;
      e_col = col_i && !in_f;

      if (in_f)                                    tg = ftag;
      else if (inwin(t, a0 + 1, la) && a0 < s)     tg = "R10";
      else if (t > s && f >= 0)                    tg = gtag;
      else                                         tg = "R9";
      chk(mii_txen_o == e_en, tg, "txen", mii_txen_o, e_en);
      chk(mii_txd_o == e_d, tg, "txd", mii_txd_o, e_d);

      if (f >= 0 && t > f && t <= d)  tg = "R3";
      else if (lb > 0 || a0 > s)      tg = (t > d) ? "R4" : "R10";
      else                            tg = "R10";
      chk(host_take_o == e_take, tg, "take", host_take_o, e_take);
      chk(col_o == e_col, "R5", "col", col_o, e_col);
      chk(link_stat_o == link_stat_i, "R8", "status", link_stat_o, link_stat_i);
    end
  endtask

  initial begin
    int f, s, d, mx;
    // sweep force rise across every nibble of frames of 1..5 nibbles
    for (int la = 1; la <= 5; la++) begin
      for (int off = 0; off <= la + 1; off++) begin
        f  = 1 + off;
        mx = (la > f) ? la : f;
        s  = mx + 2;
        d  = s + 4;
        // R2 when force arrives during the frame, R1 otherwise
        run(la, 0, f, d, 3, s, 1, d + GAP + 1, s, (f <= la) ? "R2" : "R1", "R4");
      end
    end
    // R6: force and request rise together from idle
    run(2, 0, 0, 6, 0, -1, 6 + GAP + 1, 0, 2, "R6", "R4");
    // R7: long forced period, R11: release without pending frame
    run(0, -1, 0, 3000, 0, -1, 0, 0, 2, "R7", "R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule